// File: doc/BRIEF.md
# Open-Row-Preferring Memory Read Scheduler

This block sits in front of a banked DRAM and decides which pending read goes out next. Reads arrive on a valid/ready port, each tagged with a thread number, a bank, a row and a column. They wait in an eight-slot pool. Every cycle the block may send out one read from the pool over a simple command interface. Each issued read carries a tag saying whether it found its bank with no open row, with the same row open, or with a different row open.

The choice follows two rules. The first rule prefers reads that land on the row already latched in their bank. The second rule applies among reads of equal standing and takes the one that arrived first. A bank is closed to new reads while it is still working on an earlier one, and also while its external ready line is low. The time a bank stays busy depends on the kind of access. A same-row access is short, a first access to an idle bank is medium, and an access that must swap rows is long. Because of this, a thread that keeps streaming through one row can pass older reads that would force a row swap.

One row spans 128 columns: 8 KB of row divided into 64-byte blocks. Column addresses are therefore 7 bits wide.

Top module: `rowhit_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `reqReady` is 1 and `issValid` is 0.
- R2: `reqReady` is 0 exactly when eight reads are waiting. A read offered while `reqReady` is 0 is not taken.
- R3: `issKind` is 0 when the bank has no open row, 1 when the read's row equals the open row, and 2 when a different row is open. The value 3 never appears.
- R4: Issuing a read leaves its row open in its bank. The next read issued to that bank with the same row is tagged 1.
- R5: After an issue, a bank accepts no further issue for 2 cycles (tag 1), 6 cycles (tag 0) or 10 cycles (tag 2), counted from the issue cycle. It becomes eligible again in exactly that cycle.
- R6: When any eligible read matches its bank's open row, the issued read is such a match.
- R7: Among eligible reads with the same match status, the one accepted earliest issues.
- R8: A read whose bank has its `bankReady` bit low is never issued.
- R9: A slot freed by an issue can accept a new read in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A read is offered |
| reqReady | output | 1 | The pool has a free slot |
| reqTid | input | 2 | Thread number of the offered read |
| reqBank | input | 2 | Bank of the offered read |
| reqRow | input | 16 | Row of the offered read |
| reqCol | input | 7 | Column of the offered read |
| bankReady | input | 4 | Per-bank permission to issue |
| issValid | output | 1 | A read is issued this cycle |
| issTid | output | 2 | Thread number of the issued read |
| issBank | output | 2 | Bank of the issued read |
| issRow | output | 16 | Row of the issued read |
| issCol | output | 7 | Column of the issued read |
| issKind | output | 2 | 0 idle bank, 1 same row, 2 row swap |

## Verification
A stale open-row register shows up within the next issue to that bank, as a wrong `issKind` or a wrong winner. A busy counter loaded with the wrong length shows up as an issue that comes a cycle too early or too late. The cycle-level reference in the bench catches both within one cycle. Broken age ordering or broken slot accounting appears at once as a different winner or a wrong `reqReady`. Every cycle the bench compares the winner, its tag and `reqReady` against an independent model of the pool and the banks.

// File: rtl/rowsched_pkg.sv
package rowsched_pkg;
  parameter int NUM_ENTRIES  = 8;
  parameter int NUM_BANKS    = 4;
  parameter int ROW_W        = 16;
  parameter int COL_W        = 7;
  parameter int TID_W        = 2;
  parameter int SEQ_W        = 16;
  parameter int LAT_HIT      = 2;
  parameter int LAT_EMPTY    = 6;
  parameter int LAT_CONFLICT = 10;

  localparam int IDX_W  = $clog2(NUM_ENTRIES);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CNT_W  = $clog2(LAT_CONFLICT + 1);

  typedef enum logic [1:0] {
    KIND_EMPTY    = 2'd0,
    KIND_HIT      = 2'd1,
    KIND_CONFLICT = 2'd2
  } accKind_e;

  typedef struct packed {
    logic [TID_W-1:0]  tid;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } memReq_t;

  typedef struct packed {
    logic             accept;
    logic [IDX_W-1:0] allocIdx;
    logic             issue;
    logic [IDX_W-1:0] issueIdx;
    accKind_e         issueKind;
  } schedStrobe_t;

  function automatic logic [CNT_W-1:0] holdCycles(accKind_e k);
    case (k)
      KIND_HIT:      holdCycles = CNT_W'(LAT_HIT - 1);
      KIND_EMPTY:    holdCycles = CNT_W'(LAT_EMPTY - 1);
      default:       holdCycles = CNT_W'(LAT_CONFLICT - 1);
    endcase
  endfunction

  function automatic logic isOlder(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    isOlder = diff[SEQ_W-1];
  endfunction
endpackage

// File: rtl/rowsched_dp.sv
module rowsched_dp
  import rowsched_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  memReq_t                reqIn,
  input  schedStrobe_t           strb,
  output logic [NUM_ENTRIES-1:0] entValid,
  output memReq_t                entReq [NUM_ENTRIES],
  output logic [SEQ_W-1:0]       entSeq [NUM_ENTRIES],
  output logic [NUM_BANKS-1:0]   openValid,
  output logic [ROW_W-1:0]       openRow [NUM_BANKS],
  output logic [NUM_BANKS-1:0]   bankIdle
);
  logic [SEQ_W-1:0] seqCtr;
  memReq_t          issReq;

  assign issReq = entReq[strb.issueIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            seqCtr <= '0;
    else if (strb.accept) seqCtr <= seqCtr + 1'b1;
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
    logic             slotValid;
    memReq_t          slotReq;
    logic [SEQ_W-1:0] slotSeq;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid <= 1'b0;
        slotReq   <= '0;
        slotSeq   <= '0;
      end else if (strb.issue && strb.issueIdx == IDX_W'(e)) begin
        slotValid <= 1'b0;
      end else if (strb.accept && strb.allocIdx == IDX_W'(e)) begin
        slotValid <= 1'b1;
        slotReq   <= reqIn;
        slotSeq   <= seqCtr;
      end
    end

    assign entValid[e] = slotValid;
    assign entReq[e]   = slotReq;
    assign entSeq[e]   = slotSeq;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             rowOpen;
    logic [ROW_W-1:0] rowReg;
    logic [CNT_W-1:0] busyCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowOpen <= 1'b0;
        rowReg  <= '0;
        busyCnt <= '0;
      end else if (strb.issue && issReq.bank == BANK_W'(b)) begin
        rowOpen <= 1'b1;
        rowReg  <= issReq.row;
        busyCnt <= holdCycles(strb.issueKind);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end

    assign openValid[b] = rowOpen;
    assign openRow[b]   = rowReg;
    assign bankIdle[b]  = (busyCnt == '0);
  end
endmodule

// File: rtl/rowsched_ctrl.sv
module rowsched_ctrl
  import rowsched_pkg::*;
(
  input  logic                   reqValid,
  input  logic [NUM_BANKS-1:0]   bankReady,
  input  logic [NUM_ENTRIES-1:0] entValid,
  input  memReq_t                entReq [NUM_ENTRIES],
  input  logic [SEQ_W-1:0]       entSeq [NUM_ENTRIES],
  input  logic [NUM_BANKS-1:0]   openValid,
  input  logic [ROW_W-1:0]       openRow [NUM_BANKS],
  input  logic [NUM_BANKS-1:0]   bankIdle,
  output logic                   reqReady,
  output schedStrobe_t           strb
);
  logic             anyFree;
  logic [IDX_W-1:0] freeIdx;
  logic             bestFound;
  logic             bestHit;
  logic [IDX_W-1:0] bestIdx;
  logic [SEQ_W-1:0] bestSeq;

  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (!entValid[e]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(e);
      end
    end
  end

  always_comb begin
    logic elig;
    logic hit;
    bestFound = 1'b0;
    bestHit   = 1'b0;
    bestIdx   = '0;
    bestSeq   = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      elig = entValid[e] && bankIdle[entReq[e].bank] && bankReady[entReq[e].bank];
      hit  = openValid[entReq[e].bank] && (openRow[entReq[e].bank] == entReq[e].row);
      if (elig && (!bestFound || (hit && !bestHit) ||
                   (hit == bestHit && isOlder(entSeq[e], bestSeq)))) begin
        bestFound = 1'b1;
        bestHit   = hit;
        bestIdx   = IDX_W'(e);
        bestSeq   = entSeq[e];
      end
    end
  end

  always_comb begin
    reqReady       = anyFree;
    strb.accept    = reqValid && anyFree;
    strb.allocIdx  = freeIdx;
    strb.issue     = bestFound;
    strb.issueIdx  = bestIdx;
    if (!openValid[entReq[bestIdx].bank]) strb.issueKind = KIND_EMPTY;
    else if (bestHit)                     strb.issueKind = KIND_HIT;
    else                                  strb.issueKind = KIND_CONFLICT;
  end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
  import rowsched_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [TID_W-1:0]     reqTid,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ROW_W-1:0]     reqRow,
  input  logic [COL_W-1:0]     reqCol,
  input  logic [NUM_BANKS-1:0] bankReady,
  output logic                 issValid,
  output logic [TID_W-1:0]     issTid,
  output logic [BANK_W-1:0]    issBank,
  output logic [ROW_W-1:0]     issRow,
  output logic [COL_W-1:0]     issCol,
  output logic [1:0]           issKind
);
  schedStrobe_t           strb;
  memReq_t                reqIn;
  logic [NUM_ENTRIES-1:0] entValid;
  memReq_t                entReq [NUM_ENTRIES];
  logic [SEQ_W-1:0]       entSeq [NUM_ENTRIES];
  logic [NUM_BANKS-1:0]   openValid;
  logic [ROW_W-1:0]       openRow [NUM_BANKS];
  logic [NUM_BANKS-1:0]   bankIdle;
  memReq_t                outReq;

  assign reqIn = '{tid: reqTid, bank: reqBank, row: reqRow, col: reqCol};

  rowsched_ctrl u_ctrl (
    .reqValid (reqValid),
    .bankReady(bankReady),
    .entValid (entValid),
    .entReq   (entReq),
    .entSeq   (entSeq),
    .openValid(openValid),
    .openRow  (openRow),
    .bankIdle (bankIdle),
    .reqReady (reqReady),
    .strb     (strb)
  );

  rowsched_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .strb     (strb),
    .entValid (entValid),
    .entReq   (entReq),
    .entSeq   (entSeq),
    .openValid(openValid),
    .openRow  (openRow),
    .bankIdle (bankIdle)
  );

  assign outReq   = entReq[strb.issueIdx];
  assign issValid = strb.issue;
  assign issTid   = outReq.tid;
  assign issBank  = outReq.bank;
  assign issRow   = outReq.row;
  assign issCol   = outReq.col;
  assign issKind  = strb.issueKind;
endmodule

// File: rtl/rowhit_sched_chk.sv
module rowhit_sched_chk
  import rowsched_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [NUM_BANKS-1:0] bankReady,
  input logic                 issValid,
  input logic [BANK_W-1:0]    issBank,
  input logic [ROW_W-1:0]     issRow,
  input logic [1:0]           issKind
);
  localparam int OCC_W = $clog2(NUM_ENTRIES + 1);

  logic [OCC_W-1:0] occ;
  logic [NUM_BANKS-1:0] seen;
  logic [ROW_W-1:0] lastRow [NUM_BANKS];
  logic [CNT_W-1:0] sinceIss [NUM_BANKS];
  logic [CNT_W-1:0] lastLat [NUM_BANKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else occ <= occ + OCC_W'(reqValid && reqReady) - OCC_W'(issValid);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_trk
    logic bSeen;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bSeen       <= 1'b0;
        lastRow[b]  <= '0;
        sinceIss[b] <= '0;
        lastLat[b]  <= '0;
      end else if (issValid && issBank == BANK_W'(b)) begin
        bSeen       <= 1'b1;
        lastRow[b]  <= issRow;
        sinceIss[b] <= CNT_W'(1);
        lastLat[b]  <= (issKind == 2'd1) ? CNT_W'(LAT_HIT) :
                       (issKind == 2'd0) ? CNT_W'(LAT_EMPTY) : CNT_W'(LAT_CONFLICT);
      end else if (sinceIss[b] < CNT_W'(LAT_CONFLICT)) begin
        sinceIss[b] <= sinceIss[b] + 1'b1;
      end
    end
    assign seen[b] = bSeen;
  end

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_W'(NUM_ENTRIES)) |-> !reqReady); // R2
  AST_ROOM_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (occ < OCC_W'(NUM_ENTRIES)) |-> reqReady); // R2
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    issValid |-> (issKind != 2'd3)); // R3
  AST_FIRST_IS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !seen[issBank]) |-> (issKind == 2'd0)); // R3
  AST_OPEN_ROW_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && seen[issBank]) |-> ((issKind == 2'd1) == (lastRow[issBank] == issRow))); // R4
  AST_BANK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && seen[issBank]) |-> (sinceIss[issBank] >= lastLat[issBank])); // R5
  AST_BANK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    issValid |-> bankReady[issBank]); // R8
endmodule

bind rowhit_sched rowhit_sched_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .bankReady(bankReady),
  .issValid (issValid),
  .issBank  (issBank),
  .issRow   (issRow),
  .issKind  (issKind)
);

// File: tb/rowhit_sched_tb.sv
module rowhit_sched_tb;
  import rowsched_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, reqValid, reqReady, issValid;
  logic [TID_W-1:0] reqTid, issTid;
  logic [BANK_W-1:0] reqBank, issBank;
  logic [ROW_W-1:0] reqRow, issRow;
  logic [COL_W-1:0] reqCol, issCol;
  logic [NUM_BANKS-1:0] bankReady;
  logic [1:0] issKind;

  rowhit_sched u_dut (.*);

  int compared = 0, mismatched = 0, cyc = 0, nextSeq = 0;
  memReq_t pReq[$];
  int pSeq[$];
  bit mOpenV[NUM_BANKS];
  logic [ROW_W-1:0] mOpen[NUM_BANKS];
  int mReadyAt[NUM_BANKS];
  memReq_t logReq[$];
  int logCyc[$];
  int logKind[$];

  localparam memReq_t VEC [12] = '{
    '{tid: 2'd0, bank: 2'd0, row: 16'd5,   col: 7'd1},
    '{tid: 2'd1, bank: 2'd0, row: 16'd5,   col: 7'd2},
    '{tid: 2'd1, bank: 2'd0, row: 16'd9,   col: 7'd3},
    '{tid: 2'd2, bank: 2'd1, row: 16'd1,   col: 7'd4},
    '{tid: 2'd0, bank: 2'd0, row: 16'd5,   col: 7'd5},
    '{tid: 2'd2, bank: 2'd1, row: 16'd1,   col: 7'd6},
    '{tid: 2'd3, bank: 2'd1, row: 16'd2,   col: 7'd7},
    '{tid: 2'd3, bank: 2'd2, row: 16'd3,   col: 7'd8},
    '{tid: 2'd1, bank: 2'd0, row: 16'd9,   col: 7'd9},
    '{tid: 2'd0, bank: 2'd3, row: 16'd700, col: 7'd10},
    '{tid: 2'd2, bank: 2'd3, row: 16'd701, col: 7'd11},
    '{tid: 2'd0, bank: 2'd3, row: 16'd700, col: 7'd12}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit doReq, input memReq_t r,
                      input logic [NUM_BANKS-1:0] br, output bit accepted);
    bit found, bh, h, expReady;
    int bi, expKind, lat;
    memReq_t got;
    @(negedge clk);
    reqValid = doReq;
    {reqTid, reqBank, reqRow, reqCol} = r;
    bankReady = br;
    #1;
    expReady = (pReq.size() < NUM_ENTRIES);
    chk(reqReady == expReady, "R2", "reqReady", reqReady, expReady);
    found = 0; bh = 0; bi = 0;
    for (int i = 0; i < pReq.size(); i++) begin
      int b;
      b = pReq[i].bank;
      h = mOpenV[b] && (mOpen[b] == pReq[i].row);
      if (br[b] && cyc >= mReadyAt[b] &&
          (!found || (h && !bh) || (h == bh && pSeq[i] < pSeq[bi]))) begin
        found = 1; bh = h; bi = i;
      end
    end
    chk(issValid == found, "R5", "issValid", issValid, found);
    if (found && issValid) begin
      got = '{tid: issTid, bank: issBank, row: issRow, col: issCol};
      chk(got == pReq[bi], bh ? "R6" : "R7", "issued read", got, pReq[bi]);
      expKind = !mOpenV[pReq[bi].bank] ? 0 : (bh ? 1 : 2);
      chk(issKind == 2'(expKind), "R3", "issKind", issKind, expKind);
      lat = (expKind == 1) ? LAT_HIT : (expKind == 0) ? LAT_EMPTY : LAT_CONFLICT;
      mOpenV[pReq[bi].bank] = 1;
      mOpen[pReq[bi].bank] = pReq[bi].row;
      mReadyAt[pReq[bi].bank] = cyc + lat;
      logReq.push_back(pReq[bi]);
      logCyc.push_back(cyc);
      logKind.push_back(expKind);
      pReq.delete(bi);
      pSeq.delete(bi);
    end
    accepted = doReq && reqReady;
    if (accepted) begin
      pReq.push_back(r);
      pSeq.push_back(nextSeq);
      nextSeq++;
    end
    cyc++;
  endtask

  task automatic pushReq(input memReq_t r, input logic [NUM_BANKS-1:0] br);
    bit acc;
    for (int t = 0; t < 60; t++) begin
      step(1'b1, r, br, acc);
      if (acc) return;
    end
    chk(1'b0, "R2", "push never accepted", 0, 1);
  endtask

  task automatic idle(input int n, input logic [NUM_BANKS-1:0] br);
    bit acc;
    for (int t = 0; t < n; t++) step(1'b0, '0, br, acc);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit acc;
    int n0, s;
    rstN = 0; reqValid = 0; reqTid = '0; reqBank = '0; reqRow = '0; reqCol = '0;
    bankReady = '1;
    for (int b = 0; b < NUM_BANKS; b++) begin mOpenV[b] = 0; mOpen[b] = '0; mReadyAt[b] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(reqReady == 1'b1, "R1", "reqReady in reset", reqReady, 1);
    chk(issValid == 1'b0, "R1", "issValid in reset", issValid, 0);
    @(negedge clk);
    rstN = 1;
    #1;
    chk(reqReady == 1'b1 && issValid == 1'b0, "R1", "ready/valid after reset",
        {reqReady, issValid}, 2'b10);

    // Vector table: mixed banks, repeated rows, conflicts (R3 R4 R5 R6 R7)
    for (int v = 0; v < 12; v++) pushReq(VEC[v], '1);
    idle(60, '1);
    chk(pReq.size() == 0, "R7", "vector reads all issued", pReq.size(), 0);

    // Fill with banks masked, then reuse a freed slot (R2 R8 R9)
    n0 = logReq.size();
    for (int v = 0; v < NUM_ENTRIES; v++)
      pushReq('{tid: 2'd1, bank: BANK_W'(v % NUM_BANKS), row: 16'(20 + v), col: 7'(40 + v)}, '0);
    step(1'b1, '{tid: 2'd2, bank: 2'd2, row: 16'd99, col: 7'd99}, '0, acc);
    chk(acc == 1'b0, "R2", "offer taken while full", acc, 0);
    chk(logReq.size() == n0, "R8", "issues while all banks masked", logReq.size() - n0, 0);
    step(1'b1, '{tid: 2'd2, bank: 2'd2, row: 16'd99, col: 7'd99}, 4'b0001, acc);
    chk(logReq.size() == n0 + 1 && logReq[n0].bank == 2'd0, "R8", "only unmasked bank issues",
        logReq.size() - n0, 1);
    chk(acc == 1'b0, "R2", "offer in issue cycle", acc, 0);
    step(1'b1, '{tid: 2'd2, bank: 2'd2, row: 16'd99, col: 7'd99}, '0, acc);
    chk(acc == 1'b1, "R9", "freed slot reused next cycle", acc, 1);
    idle(80, '1);

    // Streaming thread against random-row thread on one bank (R4 R5 R6)
    pushReq('{tid: 2'd0, bank: 2'd1, row: 16'd50, col: 7'd20}, '1);
    idle(12, '1);
    for (int v = 0; v < 4; v++)
      pushReq('{tid: 2'd1, bank: 2'd1, row: 16'(100 * (v + 1)), col: 7'(30 + v)}, 4'b1101);
    for (int v = 0; v < 4; v++)
      pushReq('{tid: 2'd0, bank: 2'd1, row: 16'd50, col: 7'(60 + v)}, 4'b1101);
    s = logReq.size();
    idle(80, '1);
    chk(logReq.size() == s + 8, "R6", "batch issue count", logReq.size() - s, 8);
    if (logReq.size() == s + 8) begin
      for (int k = 0; k < 4; k++) begin
        chk(logReq[s + k].tid == 2'd0, "R6", "streaming read overtakes", logReq[s + k].tid, 0);
        chk(logKind[s + k] == 1, "R4", "streaming read hits open row", logKind[s + k], 1);
      end
      chk(logCyc[s + 1] - logCyc[s] == LAT_HIT, "R5", "hit spacing",
          logCyc[s + 1] - logCyc[s], LAT_HIT);
      chk(logCyc[s + 4] - logCyc[s + 3] == LAT_HIT, "R5", "after hit",
          logCyc[s + 4] - logCyc[s + 3], LAT_HIT);
      chk(logCyc[s + 5] - logCyc[s + 4] == LAT_CONFLICT, "R5", "after conflict",
          logCyc[s + 5] - logCyc[s + 4], LAT_CONFLICT);
      chk(logReq[s + 4].col == 7'd30 && logReq[s + 7].col == 7'd33, "R7",
          "random reads keep arrival order", logReq[s + 4].col, 30);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule